// File: doc/BRIEF.md
# RV32I Integer ALU with Mode Flags

This block is the combinational arithmetic and logic unit of a small multi-cycle RV32I core. It takes two 32-bit operands and a 3-bit operation code equal to the funct3 field of the instruction. It also takes one mode flag, which chooses subtract over add and arithmetic over logical right shift. From these it forms a 32-bit result. Next to the result it always drives three comparison flags on the operands: equal, signed less-than and unsigned less-than. The core's sequencer uses these flags to decide branches.

The mode flag is not taken straight from the instruction. A small gate passes instruction bit 30 through only when the sequencer raises a pass-enable. The sequencer raises it for register-register operations and for immediate right shifts. It keeps it low for immediate add, so an immediate with bit 30 set can never turn into a subtraction. A separate force-add input makes the unit add whatever the operation code and flag are. The core uses it for address generation and for the upper-immediate instructions.

There is no clock and no reset. Every output is a pure function of the present inputs.

Top module: `rv_alu`

## Requirements
- R1: With sel_i = 0 and the gated mode flag at 0, y_o = a_i + b_i modulo 2^32.
- R2: With sel_i = 0 and the gated mode flag at 1, y_o = a_i - b_i, formed as a_i plus the two's complement of b_i.
- R3: sel_i = 4 gives a_i XOR b_i, sel_i = 6 gives a_i OR b_i, and sel_i = 7 gives a_i AND b_i.
- R4: sel_i = 1 shifts a_i left, filling with zeros, by the amount in b_i[4:0]. Bits b_i[31:5] have no effect.
- R5: sel_i = 5 shifts a_i right by b_i[4:0]. With the gated mode flag at 0 it fills with zeros. With the flag at 1 it fills with copies of a_i[31].
- R6: sel_i = 2 gives 1 when a_i < b_i as signed two's-complement numbers, and 0 otherwise. sel_i = 3 makes the same comparison unsigned. In both cases y_o[31:1] is 0.
- R7: When force_add_i is 1, y_o = a_i + b_i, whatever sel_i, ir_bit30_i and flag_en_i are.
- R8: eq_o = (a_i == b_i), lt_o = signed(a_i) < signed(b_i), and ltu_o = a_i < b_i unsigned. All three hold for every value of sel_i and force_add_i.
- R9: The gated mode flag equals ir_bit30_i when flag_en_i is 1, and 0 when flag_en_i is 0. So with flag_en_i = 0 and ir_bit30_i = 1, sel_i = 0 adds and sel_i = 5 shifts logically.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_i | input | 32 | First operand |
| b_i | input | 32 | Second operand; bits 4:0 give the shift amount |
| sel_i | input | 3 | Operation code, equal to funct3 |
| ir_bit30_i | input | 1 | Instruction bit 30, the raw mode bit |
| flag_en_i | input | 1 | Pass-enable for the mode bit, from the sequencer |
| force_add_i | input | 1 | Forces addition when 1 |
| y_o | output | 32 | Result |
| eq_o | output | 1 | Operands are equal |
| lt_o | output | 1 | a_i less than b_i, signed |
| ltu_o | output | 1 | a_i less than b_i, unsigned |

## Verification
The block holds no state, so a fault inside it shows at the ports in the same evaluation as the input pattern that exposes it. No later cycle hides it or delays it. The faults that matter most are a dropped or inverted mode-flag gate, the wrong fill bit or a wrong stage in the shift network, and a sign mix-up in the signed comparison. Each of these changes y_o or a status flag at once, for operands chosen at the boundaries: sign-bit patterns, shift amounts of 0 and 31, and shift operands with upper bits set. A seeded sweep against a reference model built from the requirements also covers patterns that the directed checks miss.

// File: rtl/rv_alu_pkg.sv
package rv_alu_pkg;

    localparam int XLEN = 32;
    localparam int SHW  = $clog2(XLEN);

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SLL  = 3'd1,
        OP_SLT  = 3'd2,
        OP_SLTU = 3'd3,
        OP_XOR  = 3'd4,
        OP_SR   = 3'd5,
        OP_OR   = 3'd6,
        OP_AND  = 3'd7
    } alu_op_e;

endpackage

// File: rtl/alu_flag_gate.sv
module alu_flag_gate (
    input  logic bit30_i,
    input  logic en_i,
    output logic flag_o
);
    // Mode bit reaches the datapath only when the sequencer allows it.
    always_comb begin
        flag_o = 1'b0;
        if (en_i) flag_o = bit30_i;
    end
endmodule

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o
);
    logic [W-1:0] b_eff;

    always_comb begin
        b_eff = sub_i ? ~b_i : b_i;
        sum_o = a_i + b_eff + {{(W-1){1'b0}}, sub_i};
    end

    // R2: adding B back after a subtraction returns A.
    always_comb begin
        if (sub_i) begin
            p_sub_inverse_r2: assert (sum_o + b_i == a_i);
        end
    end
endmodule

// File: rtl/alu_shifter.sv
module alu_shifter #(
    parameter int W = 32,
    localparam int SW = $clog2(W)
) (
    input  logic [W-1:0]  val_i,
    input  logic [SW-1:0] amt_i,
    input  logic          left_i,
    input  logic          arith_i,
    output logic [W-1:0]  res_o
);
    logic [W-1:0]  rev_in;
    logic [W-1:0]  rev_out;
    logic [W-1:0]  base;
    logic [W-1:0]  stage [0:SW];
    logic          fill;

    // Left shifts reuse the right shifter on a bit-reversed operand.
    for (genvar k = 0; k < W; k++) begin : g_rev_in
        assign rev_in[k] = val_i[W-1-k];
    end

    assign base     = left_i ? rev_in : val_i;
    assign fill     = arith_i & ~left_i & val_i[W-1];
    assign stage[0] = base;

    for (genvar s = 0; s < SW; s++) begin : g_stage
        localparam int STEP = 1 << s;
        assign stage[s+1] = amt_i[s]
            ? {{STEP{fill}}, stage[s][W-1:STEP]}
            : stage[s];
    end

    for (genvar k = 0; k < W; k++) begin : g_rev_out
        assign rev_out[k] = stage[SW][W-1-k];
    end

    assign res_o = left_i ? rev_out : stage[SW];

    always_comb begin
        // R4: a zero shift amount leaves the operand unchanged.
        if (amt_i == '0) begin
            p_zero_amt_r4: assert (res_o == val_i);
        end
        // R5: an arithmetic right shift of a negative value stays negative.
        if (arith_i && !left_i && val_i[W-1]) begin
            p_arith_fill_r5: assert (res_o[W-1]);
        end
        // R4: the left shift never sets bit 0 unless the amount is 0.
        if (left_i && amt_i != '0) begin
            p_sll_low_zero_r4: assert (!res_o[0]);
        end
    end
endmodule

// File: rtl/alu_compare.sv
module alu_compare #(
    parameter int W = 32
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic         eq_o,
    output logic         lt_o,
    output logic         ltu_o
);
    logic [W:0] diff;

    always_comb begin
        diff  = {1'b0, a_i} - {1'b0, b_i};
        eq_o  = (diff[W-1:0] == '0);
        ltu_o = diff[W];
        lt_o  = (a_i[W-1] != b_i[W-1]) ? a_i[W-1] : diff[W];
    end

    always_comb begin
        // R8: equality excludes both orderings.
        if (eq_o) begin
            p_eq_excl_r8: assert (!lt_o && !ltu_o);
        end
        // R8: with the same sign bit the signed and unsigned orders agree.
        if (a_i[W-1] == b_i[W-1]) begin
            p_same_sign_r8: assert (lt_o == ltu_o);
        end
    end
endmodule

// File: rtl/rv_alu.sv
module rv_alu
    import rv_alu_pkg::*;
(
    input  logic [XLEN-1:0] a_i,
    input  logic [XLEN-1:0] b_i,
    input  logic [2:0]      sel_i,
    input  logic            ir_bit30_i,
    input  logic            flag_en_i,
    input  logic            force_add_i,
    output logic [XLEN-1:0] y_o,
    output logic            eq_o,
    output logic            lt_o,
    output logic            ltu_o
);
    alu_op_e         op;
    logic            mode_flag;
    logic            do_sub;
    logic            do_left;
    logic [XLEN-1:0] sum;
    logic [XLEN-1:0] shifted;

    assign op      = alu_op_e'(sel_i);
    assign do_sub  = mode_flag & (op == OP_ADD) & ~force_add_i;
    assign do_left = (op == OP_SLL);

    alu_flag_gate u_gate (
        .bit30_i (ir_bit30_i),
        .en_i    (flag_en_i),
        .flag_o  (mode_flag)
    );

    alu_addsub #(.W(XLEN)) u_addsub (
        .a_i   (a_i),
        .b_i   (b_i),
        .sub_i (do_sub),
        .sum_o (sum)
    );

    alu_shifter #(.W(XLEN)) u_shift (
        .val_i   (a_i),
        .amt_i   (b_i[SHW-1:0]),
        .left_i  (do_left),
        .arith_i (mode_flag),
        .res_o   (shifted)
    );

    alu_compare #(.W(XLEN)) u_cmp (
        .a_i   (a_i),
        .b_i   (b_i),
        .eq_o  (eq_o),
        .lt_o  (lt_o),
        .ltu_o (ltu_o)
    );

    always_comb begin
        if (force_add_i) begin
            y_o = sum;
        end else begin
            unique case (op)
                OP_ADD:  y_o = sum;
                OP_SLL:  y_o = shifted;
                OP_SLT:  y_o = {{(XLEN-1){1'b0}}, lt_o};
                OP_SLTU: y_o = {{(XLEN-1){1'b0}}, ltu_o};
                OP_XOR:  y_o = a_i ^ b_i;
                OP_SR:   y_o = shifted;
                OP_OR:   y_o = a_i | b_i;
                OP_AND:  y_o = a_i & b_i;
                default: y_o = sum;
            endcase
        end
    end

    always_comb begin
        // R6: set-less-than results hold only bit 0, taken from the comparator.
        if (!force_add_i && op == OP_SLT) begin
            p_slt_zext_r6: assert (y_o[XLEN-1:1] == '0 && y_o[0] == lt_o);
        end
        if (!force_add_i && op == OP_SLTU) begin
            p_sltu_zext_r6: assert (y_o[XLEN-1:1] == '0 && y_o[0] == ltu_o);
        end
        // R9: with the pass-enable low, operation 0 always adds.
        if (!flag_en_i && op == OP_ADD) begin
            p_imm_no_sub_r9: assert (y_o - b_i == a_i);
        end
        // R7: a forced add always yields the operand sum.
        if (force_add_i) begin
            p_force_sum_r7: assert (y_o - a_i == b_i);
        end
        // R2: subtracting equal operands yields zero.
        if (do_sub && eq_o) begin
            p_sub_equal_zero_r2: assert (y_o == '0);
        end
    end
endmodule

// File: tb/rv_alu_bench.sv
module rv_alu_bench;

    typedef struct {
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] exp_y;
        logic        exp_eq;
        logic        exp_lt;
        logic        exp_ltu;
        string       tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] a_i = '0;
    logic [31:0] b_i = '0;
    logic [2:0]  sel_i = '0;
    logic        ir_bit30_i = 1'b0;
    logic        flag_en_i = 1'b0;
    logic        force_add_i = 1'b0;
    logic [31:0] y_o;
    logic        eq_o, lt_o, ltu_o;

    item_t       sb_q[$];
    int          n_checks = 0;
    int          n_fail = 0;
    bit          drive_done = 1'b0;
    bit          finished = 1'b0;
    logic [31:0] rng = 32'h1234_5678;

    always #10 clk = ~clk;

    rv_alu u_rv_alu (
        .a_i         (a_i),
        .b_i         (b_i),
        .sel_i       (sel_i),
        .ir_bit30_i  (ir_bit30_i),
        .flag_en_i   (flag_en_i),
        .force_add_i (force_add_i),
        .y_o         (y_o),
        .eq_o        (eq_o),
        .lt_o        (lt_o),
        .ltu_o       (ltu_o)
    );

    // Reference result built from the requirements.
    function automatic logic [31:0] ref_y(logic [31:0] a, logic [31:0] b,
                                          logic [2:0] sel, logic b30,
                                          logic en, logic frc);
        logic       f;
        logic [4:0] sh;
        f  = en & b30;
        sh = b[4:0];
        if (frc) return a + b;
        case (sel)
            3'd0: return f ? a - b : a + b;
            3'd1: return a << sh;
            3'd2: return {31'd0, $signed(a) < $signed(b)};
            3'd3: return {31'd0, a < b};
            3'd4: return a ^ b;
            3'd5: return f ? $unsigned($signed(a) >>> sh) : a >> sh;
            3'd6: return a | b;
            default: return a & b;
        endcase
    endfunction

    task automatic push(logic [31:0] a, logic [31:0] b, logic [2:0] sel,
                        logic b30, logic en, logic frc,
                        logic [31:0] exp_y, string tag);
        item_t it;
        @(posedge clk);
        a_i = a; b_i = b; sel_i = sel;
        ir_bit30_i = b30; flag_en_i = en; force_add_i = frc;
        it.a = a; it.b = b; it.exp_y = exp_y;
        it.exp_eq  = (a == b);
        it.exp_lt  = ($signed(a) < $signed(b));
        it.exp_ltu = (a < b);
        it.tag = tag;
        sb_q.push_back(it);
    endtask

    task automatic push_ref(logic [31:0] a, logic [31:0] b, logic [2:0] sel,
                            logic b30, logic en, logic frc, string tag);
        push(a, b, sel, b30, en, frc, ref_y(a, b, sel, b30, en, frc), tag);
    endtask

    // Monitor: compare half a cycle after each drive.
    always @(negedge clk) begin
        if (rst_n && sb_q.size() != 0) begin
            item_t it;
            it = sb_q.pop_front();
            n_checks++;
            if (y_o !== it.exp_y || eq_o !== it.exp_eq ||
                lt_o !== it.exp_lt || ltu_o !== it.exp_ltu) begin
                n_fail++;
                $display("FAIL %s: a=%h b=%h y=%h eq=%b lt=%b ltu=%b expected y=%h eq=%b lt=%b ltu=%b",
                         it.tag, it.a, it.b, y_o, eq_o, lt_o, ltu_o,
                         it.exp_y, it.exp_eq, it.exp_lt, it.exp_ltu);
            end
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        // Idle pattern: all inputs zero.
        push(32'h0, 32'h0, 3'd0, 1'b0, 1'b0, 1'b0, 32'h0, "R8 idle");
        // R1
        push(32'h7FFF_FFFF, 32'h1, 3'd0, 1'b0, 1'b1, 1'b0, 32'h8000_0000, "R1");
        push(32'hFFFF_FFFF, 32'h2, 3'd0, 1'b0, 1'b1, 1'b0, 32'h1, "R1 wrap");
        // R2
        push(32'h5, 32'h7, 3'd0, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFE, "R2");
        push(32'h1234_5678, 32'h1234_5678, 3'd0, 1'b1, 1'b1, 1'b0, 32'h0, "R2 equal");
        // R9
        push(32'h5, 32'h7, 3'd0, 1'b1, 1'b0, 1'b0, 32'hC, "R9 gate off");
        push(32'h5, 32'h7, 3'd0, 1'b0, 1'b1, 1'b0, 32'hC, "R9 bit low");
        push(32'h8000_0000, 32'h4, 3'd5, 1'b1, 1'b0, 1'b0, 32'h0800_0000, "R9 shift gate off");
        // R3
        push(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd4, 1'b0, 1'b1, 1'b0, 32'hFF00_FF00, "R3 xor");
        push(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd6, 1'b0, 1'b1, 1'b0, 32'hFFF0_FFF0, "R3 or");
        push(32'hF0F0_F0F0, 32'h0FF0_0FF0, 3'd7, 1'b0, 1'b1, 1'b0, 32'h00F0_00F0, "R3 and");
        // R4
        push(32'h1, 32'hFFFF_FFE1, 3'd1, 1'b0, 1'b1, 1'b0, 32'h2, "R4 upper b ignored");
        push(32'h8000_0001, 32'd31, 3'd1, 1'b0, 1'b1, 1'b0, 32'h8000_0000, "R4 by 31");
        push(32'hDEAD_BEEF, 32'h20, 3'd1, 1'b0, 1'b1, 1'b0, 32'hDEAD_BEEF, "R4 by 0");
        // R5
        push(32'h8000_0000, 32'h4, 3'd5, 1'b0, 1'b1, 1'b0, 32'h0800_0000, "R5 srl");
        push(32'h8000_0000, 32'h4, 3'd5, 1'b1, 1'b1, 1'b0, 32'hF800_0000, "R5 sra");
        push(32'h8000_0000, 32'd31, 3'd5, 1'b1, 1'b1, 1'b0, 32'hFFFF_FFFF, "R5 sra 31");
        push(32'h7000_0000, 32'h3C, 3'd5, 1'b1, 1'b1, 1'b0, 32'h0000_0007, "R5 sra positive");
        // R6
        push(32'hFFFF_FFFF, 32'h1, 3'd2, 1'b0, 1'b1, 1'b0, 32'h1, "R6 slt");
        push(32'hFFFF_FFFF, 32'h1, 3'd3, 1'b0, 1'b1, 1'b0, 32'h0, "R6 sltu");
        push(32'h1, 32'h8000_0000, 3'd3, 1'b0, 1'b1, 1'b0, 32'h1, "R6 sltu high");
        // R7
        push(32'h3, 32'h4, 3'd5, 1'b1, 1'b1, 1'b1, 32'h7, "R7 over shift");
        push(32'hA, 32'h3, 3'd0, 1'b1, 1'b1, 1'b1, 32'hD, "R7 over sub");
        push(32'hFFFF_FFFF, 32'h1, 3'd2, 1'b0, 1'b0, 1'b1, 32'h0, "R7 over slt");
        // R8
        push(32'hFFFF_FFFF, 32'h1, 3'd4, 1'b0, 1'b1, 1'b0, 32'hFFFF_FFFE, "R8 flags xor");
        push(32'h8000_0000, 32'h7FFF_FFFF, 3'd6, 1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R8 flags force");
        // Seeded sweep over all modes.
        for (int i = 0; i < 400; i++) begin
            logic [31:0] ra, rb;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            ra = rng;
            rng = rng ^ (rng << 13); rng = rng ^ (rng >> 17); rng = rng ^ (rng << 5);
            rb = (i % 5 == 0) ? ra : rng;
            push_ref(ra, rb, rng[2:0], rng[8], rng[9], (rng[15:12] == 4'd0),
                     "R1 R2 R3 R4 R5 R6 R7 R8 R9 sweep");
        end
        @(posedge clk);
        @(posedge clk);
        drive_done = 1'b1;
    end

    initial begin
        wait (drive_done && sb_q.size() == 0);
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung, expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule